// File: doc/BRIEF.md
# Programmable Dual-Range Hit Delay Line

This block re-times single-bit hit signals so that hits arriving over cables of unequal length line up in the same bunch crossing before they reach the coincidence logic. It runs on the 40 MHz bunch clock, so one delay step equals one 25 ns bunch period. Each channel carries its own delay setting, applied through static configuration inputs.

There are two classes of channel. Near channels get a 2-bit setting and up to 3 ticks of delay, about 75 ns. Far channels get a 4-bit setting and up to 10 ticks, about 250 ns. A far setting above 10 is clamped to 10. Inside each class, every channel has a chain of flip-flops. A tap multiplexer picks either the raw input or one of the chain stages. The picked bit goes through one output register, so every channel has one fixed extra tick of latency on top of its programmed delay.

A small control stage turns each raw setting into a tap command: a bypass strobe plus a stage index. The datapath takes only these commands. The same control and datapath modules are built once for each class, with the depth as a parameter.

Top module: `dual_range_delay`

## Requirements
- R1: While the synchronous reset is high at a clock edge, every output is 0 after that edge. All stored pipeline bits are also cleared, so no hit that entered before the reset appears at an output afterwards.
- R2: With a setting of 0, a channel's output after a clock edge equals its input sampled at that same edge. The only added latency is the single output register.
- R3: A near channel with setting d (1 to 3) presents, after edge k, the input it sampled at edge k-d.
- R4: A far channel with setting d (1 to 10) presents, after edge k, the input it sampled at edge k-d.
- R5: A far-channel setting of 11 to 15 behaves exactly like a setting of 10.
- R6: A new setting is used from the next clock edge onward. Hits already stored in the chain are kept, so after the change the output shows the stored history at the new depth.
- R7: Each channel follows only its own input and its own setting. Channels in the same class with different settings do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| nearIn | input | NEAR_LANES | Hit inputs of the near class |
| nearSel | input | NEAR_LANES*NEAR_SEL_W | Per-channel near delay setting, channel 0 in the lowest bits |
| farIn | input | FAR_LANES | Hit inputs of the far class |
| farSel | input | FAR_LANES*FAR_SEL_W | Per-channel far delay setting, channel 0 in the lowest bits |
| nearOut | output | NEAR_LANES | Delayed near hits, registered |
| farOut | output | FAR_LANES | Delayed far hits, registered |

## Verification
The bench builds the block with its default parameters: four near channels of depth 3 with 2-bit settings, and four far channels of depth 10 with 4-bit settings. With these values it can sweep every legal depth in both classes. The 4-bit far setting also reaches the codes 11 to 15, which exercises clamping. Four lanes per class leave room to give neighbouring channels different settings at the same time and to change settings while hits are still stored in the chains.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic              bypass;
    logic [IDX_W-1:0]  tapIdx;
  } tapCmd_t;
endpackage

// File: rtl/delay_ctrl.sv
module delay_ctrl
  import dly_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEL_W = 4,
  parameter int MAX_D = 10
) (
  input  logic [LANES*SEL_W-1:0] selIn,
  output tapCmd_t [LANES-1:0]    cmd
);
  localparam int CAP_IDX = MAX_D - 1;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [SEL_W-1:0] sel;
      sel = selIn[l*SEL_W +: SEL_W];
      cmd[l].bypass = 1'b0;
      cmd[l].tapIdx = '0;
      if (sel == '0) begin
        cmd[l].bypass = 1'b1;
      end else if (int'(sel) >= MAX_D) begin
        cmd[l].tapIdx = IDX_W'(CAP_IDX);
      end else begin
        cmd[l].tapIdx = IDX_W'(sel) - IDX_W'(1);
      end
    end
  end

  // the datapath only has MAX_D stages; any command must stay inside them
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      p_tap_in_range_r5: assert (cmd[l].bypass || int'(cmd[l].tapIdx) < MAX_D)
        else $error("tap index beyond chain depth");
    end
  end
endmodule

// File: rtl/delay_datapath.sv
module delay_datapath
  import dly_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES-1:0]     laneIn,
  input  tapCmd_t [LANES-1:0]  cmd,
  output logic [LANES-1:0]     laneOut
);
  localparam int SEL_B = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] stage;
    logic             tapBit;

    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= laneIn[l];
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[DEPTH-2:0], laneIn[l]};
      end
    end

    always_comb begin
      if (cmd[l].bypass) tapBit = laneIn[l];
      else               tapBit = stage[cmd[l].tapIdx[SEL_B-1:0]];
    end

    always_ff @(posedge clk) begin
      if (rst) laneOut[l] <= 1'b0;
      else     laneOut[l] <= tapBit;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (laneOut[l] == 1'b0 && stage == '0))
      else $error("reset left data in lane");

    p_bypass_follow_r2: assert property (@(posedge clk) disable iff (rst)
      cmd[l].bypass |=> laneOut[l] == $past(laneIn[l]))
      else $error("zero setting did not pass input through");

    p_quiet_chain_r7: assert property (@(posedge clk) disable iff (rst)
      (stage == '0 && laneIn[l] == 1'b0) |=> (stage == '0 && laneOut[l] == 1'b0))
      else $error("idle lane produced a hit");
  end
endmodule

// File: rtl/dual_range_delay.sv
module dual_range_delay
  import dly_pkg::*;
#(
  parameter int NEAR_LANES = 4,
  parameter int NEAR_SEL_W = 2,
  parameter int NEAR_DEPTH = 3,
  parameter int FAR_LANES  = 4,
  parameter int FAR_SEL_W  = 4,
  parameter int FAR_DEPTH  = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NEAR_LANES-1:0]          nearIn,
  input  logic [NEAR_LANES*NEAR_SEL_W-1:0] nearSel,
  input  logic [FAR_LANES-1:0]           farIn,
  input  logic [FAR_LANES*FAR_SEL_W-1:0] farSel,
  output logic [NEAR_LANES-1:0]          nearOut,
  output logic [FAR_LANES-1:0]           farOut
);
  tapCmd_t [NEAR_LANES-1:0] nearCmd;
  tapCmd_t [FAR_LANES-1:0]  farCmd;

  delay_ctrl #(.LANES(NEAR_LANES), .SEL_W(NEAR_SEL_W), .MAX_D(NEAR_DEPTH)) uNearCtrl (
    .selIn (nearSel),
    .cmd   (nearCmd)
  );

  delay_datapath #(.LANES(NEAR_LANES), .DEPTH(NEAR_DEPTH)) uNearPath (
    .clk     (clk),
    .rst     (rst),
    .laneIn  (nearIn),
    .cmd     (nearCmd),
    .laneOut (nearOut)
  );

  delay_ctrl #(.LANES(FAR_LANES), .SEL_W(FAR_SEL_W), .MAX_D(FAR_DEPTH)) uFarCtrl (
    .selIn (farSel),
    .cmd   (farCmd)
  );

  delay_datapath #(.LANES(FAR_LANES), .DEPTH(FAR_DEPTH)) uFarPath (
    .clk     (clk),
    .rst     (rst),
    .laneIn  (farIn),
    .cmd     (farCmd),
    .laneOut (farOut)
  );
endmodule

// File: tb/tb_dual_range_delay.sv
module tb_dual_range_delay;
  localparam int NL = 4, NW = 2, ND = 3;
  localparam int FL = 4, FW = 4, FD = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [NL-1:0] nearIn;
  logic [NL*NW-1:0] nearSel;
  logic [FL-1:0] farIn;
  logic [FL*FW-1:0] farSel;
  logic [NL-1:0] nearOut;
  logic [FL-1:0] farOut;

  dual_range_delay dut (
    .clk(clk), .rst(rst),
    .nearIn(nearIn), .nearSel(nearSel),
    .farIn(farIn), .farSel(farSel),
    .nearOut(nearOut), .farOut(farOut)
  );

  int checks = 0;
  int errors = 0;
  string req = "R1";

  // reference: histories of sampled inputs, index 0 = previous edge
  int hNear [NL][16];
  int hFar  [FL][16];
  logic [NL-1:0] expNear;
  logic [FL-1:0] expFar;

  function automatic int clampD(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (hNear[i, j]) hNear[i][j] = 0;
      foreach (hFar[i, j])  hFar[i][j]  = 0;
      expNear = '0;
      expFar  = '0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        int d;
        d = clampD(int'(nearSel[l*NW +: NW]), ND);
        expNear[l] = (d == 0) ? nearIn[l] : hNear[l][d-1][0];
        for (int j = 15; j > 0; j--) hNear[l][j] = hNear[l][j-1];
        hNear[l][0] = int'(nearIn[l]);
      end
      for (int l = 0; l < FL; l++) begin
        int d;
        d = clampD(int'(farSel[l*FW +: FW]), FD);
        expFar[l] = (d == 0) ? farIn[l] : hFar[l][d-1][0];
        for (int j = 15; j > 0; j--) hFar[l][j] = hFar[l][j-1];
        hFar[l][0] = int'(farIn[l]);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    checks++;
    if (nearOut !== expNear) begin
      errors++;
      $display("FAIL %s near out=%b exp=%b", req, nearOut, expNear);
    end
    checks++;
    if (farOut !== expFar) begin
      errors++;
      $display("FAIL %s far out=%b exp=%b", req, farOut, expFar);
    end
  endtask

  task automatic randData();
    nearIn = NL'($urandom);
    farIn  = FL'($urandom);
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      randData();
    end
  endtask

  function automatic logic [FL*FW-1:0] fillFar(int v);
    logic [FL*FW-1:0] r;
    for (int l = 0; l < FL; l++) r[l*FW +: FW] = FW'(v);
    return r;
  endfunction

  function automatic logic [NL*NW-1:0] fillNear(int v);
    logic [NL*NW-1:0] r;
    for (int l = 0; l < NL; l++) r[l*NW +: NW] = NW'(v);
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired in %s", req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    nearSel = fillNear(3);
    farSel  = fillFar(10);
    randData();
    // R1: outputs held at zero in reset, nothing leaks afterwards
    req = "R1";
    runFor(3);
    rst = 1'b0;
    nearIn = '0; farIn = '0;
    for (int i = 0; i < 12; i++) tick();

    req = "R2";
    nearSel = '0; farSel = '0;
    runFor(20);

    req = "R3";
    for (int d = 1; d <= 3; d++) begin
      nearSel = fillNear(d);
      farSel  = fillFar(d);
      runFor(20);
    end

    req = "R4";
    for (int d = 1; d <= 10; d++) begin
      farSel = fillFar(d);
      runFor(25);
    end

    req = "R5";
    for (int d = 11; d <= 15; d++) begin
      farSel = fillFar(d);
      runFor(25);
    end

    req = "R6";
    for (int k = 0; k < 40; k++) begin
      nearSel = NL*NW'($urandom);
      farSel  = FL*FW'($urandom);
      runFor(3);
    end

    req = "R7";
    nearSel = {2'd3, 2'd2, 2'd1, 2'd0};
    farSel  = {4'd10, 4'd7, 4'd3, 4'd0};
    runFor(30);
    nearIn = 4'b0100; farIn = 4'b1000;
    tick();
    nearIn = '0; farIn = '0;
    for (int i = 0; i < 14; i++) tick();

    // R1 again: reset with hits stored deep in the chains
    req = "R1";
    farSel = fillFar(10);
    nearSel = fillNear(3);
    nearIn = '1; farIn = '1;
    for (int i = 0; i < 6; i++) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    nearIn = '0; farIn = '0;
    for (int i = 0; i < 14; i++) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule